// File: doc/BRIEF.md
# Packet Bank Store Controller

This block sits after a delay buffer that carries fully encapsulated UDP packets one 32-bit word per cycle. The packet's class travels with its first word: a flag that says whether the packet is UDP, and the value of the first 32-bit word of the UDP payload. Because of the delay buffer, the class is already known when the first word arrives. The block then decides where the packet's words are written.

A program packet (tag word zero) has its payload written, without the tag word, into one of two program banks. The two banks are used in turn. A data packet (tag word one) is written whole, headers and trailers included, into one of several data banks. The bank is chosen by rotating through the banks from a pointer. At the end of the packet the bank is marked occupied and its length in words is recorded. Any other packet is not stored. Its words are sent out on a pass-through port.

A downstream consumer releases data banks when it has finished with them. Upstream sees a ready flag that drops while every data bank is occupied.

Top module: `pbs_store_ctrl`

## Requirements
- R1: A UDP packet whose tag value at the first word is 0x00000000 is a program packet. Each payload word (in_pay=1) after the first payload word is written to the program port at word addresses 0,1,2… within the current program bank. Header, trailer and tag words are not written.
- R2: A UDP packet whose tag value is 0x00000001 is a data packet. Every word of it is written to the data port at word addresses 0,1,2… of the chosen bank, and data_addr is {bank, word}.
- R3: A packet with any other tag value, or with cls_udp=0, is not stored. Each of its words appears on pass_valid/pass_data.
- R4: A data packet is placed in the first unoccupied bank, searched upward from the rotation pointer with wrap-around. After the packet is stored, the pointer moves to the bank after the one used.
- R5: At the last word of a data packet the bank's bank_full bit is set and its bank_len field records the packet's word count, limited to DEPTH. Words past DEPTH are not written.
- R6: While every bank is occupied, in_ready is 0. A data packet that arrives then is dropped and leaves all flags unchanged. An occupied bank is never written.
- R7: A cycle with free_valid=1 clears bank_full[free_idx].
- R8: The program bank alternates after each program packet. prog_done pulses for one cycle with prog_done_bank naming the bank just filled. Program words past PDEPTH are not written.
- R9: wr_grant is 1 from the cycle after the first word of a stored multi-word data packet until the cycle after its last word, and 0 at all other times.
- R10: All write, pass and done outputs are registered and appear one cycle after the input word. After reset no output is active, all banks are free, in_ready is 1, and the pointer and the program bank are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream word valid |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_pay | input | 1 | Word belongs to the UDP payload |
| in_data | input | 32 | Stream word |
| cls_udp | input | 1 | Packet is UDP (sampled with in_sop) |
| cls_tag | input | 32 | First payload word (sampled with in_sop) |
| in_ready | output | 1 | At least one data bank free |
| free_valid | input | 1 | Release a data bank |
| free_idx | input | BW | Bank to release |
| data_we | output | 1 | Data memory write |
| data_addr | output | BW+DAW | {bank, word} |
| data_wdata | output | 32 | Data memory word |
| prog_we | output | 1 | Program memory write |
| prog_addr | output | 1+PAW | {program bank, word} |
| prog_wdata | output | 32 | Program memory word |
| prog_done | output | 1 | Program packet finished |
| prog_done_bank | output | 1 | Bank of finished program |
| pass_valid | output | 1 | Pass-through word valid |
| pass_data | output | 32 | Pass-through word |
| wr_grant | output | 1 | Data packet store in progress |
| bank_full | output | NB | Per-bank occupied flags |
| bank_len | output | NB*LW | Per-bank stored length, bank i at [i*LW +: LW] |

## Verification
The assertions rely on two things from upstream. Packets are well framed: every packet opens with in_sop and ends with in_eop. The consumer releases only banks that are already occupied, and never the bank being written. The stimulus sends only framed packets with gaps between them. It frees only banks that the reference model reports as occupied, at times when the writer holds another bank. A free that lands during a program packet is included on purpose. The reference model predicts every output on every clock, including the rotation order after a free, the length limit, and dropped packets.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_PROG,
        MODE_DATA,
        MODE_PASS,
        MODE_DROP
    } mode_e;

    typedef enum logic [1:0] {
        KIND_PROG,
        KIND_DATA,
        KIND_OTHER
    } kind_e;

    localparam logic [31:0] TAG_PROG = 32'h0000_0000;
    localparam logic [31:0] TAG_DATA = 32'h0000_0001;
endpackage

// File: rtl/pbs_classify.sv
module pbs_classify
    import pbs_pkg::*;
(
    input  logic        is_udp,
    input  logic [31:0] tag,
    output kind_e       kind
);
    always_comb begin
        if (!is_udp)               kind = KIND_OTHER;
        else if (tag == TAG_PROG)  kind = KIND_PROG;
        else if (tag == TAG_DATA)  kind = KIND_DATA;
        else                       kind = KIND_OTHER;
    end
endmodule

// File: rtl/pbs_bank_pick.sv
module pbs_bank_pick #(
    parameter int NB = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [BW-1:0] start,
    input  logic [NB-1:0] busy,
    output logic          found,
    output logic [BW-1:0] idx
);
    logic [NB-1:0][BW-1:0] cand;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_cand
            assign cand[g] = start + BW'(g);
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (!busy[cand[k]]) begin
                found = 1'b1;
                idx   = cand[k];
            end
        end
    end
endmodule

// File: rtl/pbs_store_ctrl.sv
module pbs_store_ctrl
    import pbs_pkg::*;
#(
    parameter int NB     = 4,
    parameter int DEPTH  = 16,
    parameter int PDEPTH = 16,
    localparam int BW    = (NB > 1) ? $clog2(NB) : 1,
    localparam int DAW   = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int PAW   = $clog2(PDEPTH),
    localparam int PLW   = $clog2(PDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_pay,
    input  logic [31:0]       in_data,
    input  logic              cls_udp,
    input  logic [31:0]       cls_tag,
    output logic              in_ready,
    input  logic              free_valid,
    input  logic [BW-1:0]     free_idx,
    output logic              data_we,
    output logic [BW+DAW-1:0] data_addr,
    output logic [31:0]       data_wdata,
    output logic              prog_we,
    output logic [PAW:0]      prog_addr,
    output logic [31:0]       prog_wdata,
    output logic              prog_done,
    output logic              prog_done_bank,
    output logic              pass_valid,
    output logic [31:0]       pass_data,
    output logic              wr_grant,
    output logic [NB-1:0]     bank_full,
    output logic [NB*LW-1:0]  bank_len
);
    typedef struct packed {
        mode_e                 mode;
        logic [BW-1:0]         cur_bank;
        logic [LW-1:0]         wcnt;
        logic [PLW-1:0]        pcnt;
        logic                  seen_tag;
        logic [BW-1:0]         ptr;
        logic [NB-1:0]         full;
        logic [NB-1:0][LW-1:0] len;
        logic                  pbank;
        logic                  data_we;
        logic [BW+DAW-1:0]     data_addr;
        logic [31:0]           data_wdata;
        logic                  prog_we;
        logic [PAW:0]          prog_addr;
        logic [31:0]           prog_wdata;
        logic                  prog_done;
        logic                  prog_done_bank;
        logic                  pass_valid;
        logic [31:0]           pass_data;
    } state_t;

    state_t        s_q, s_d;
    kind_e         kind;
    logic [NB-1:0] full_mid;
    logic          pick_found;
    logic [BW-1:0] pick_idx;

    pbs_classify u_classify (
        .is_udp (cls_udp),
        .tag    (cls_tag),
        .kind   (kind)
    );

    always_comb begin
        full_mid = s_q.full;
        if (free_valid) full_mid[free_idx] = 1'b0;
    end

    pbs_bank_pick #(.NB(NB)) u_pick (
        .start (s_q.ptr),
        .busy  (full_mid),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        s_d            = s_q;
        s_d.full       = full_mid;
        s_d.data_we    = 1'b0;
        s_d.prog_we    = 1'b0;
        s_d.prog_done  = 1'b0;
        s_d.pass_valid = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                unique case (kind)
                    KIND_PROG: begin
                        s_d.mode     = MODE_PROG;
                        s_d.pcnt     = '0;
                        s_d.seen_tag = 1'b0;
                    end
                    KIND_DATA: begin
                        if (pick_found) begin
                            s_d.mode     = MODE_DATA;
                            s_d.cur_bank = pick_idx;
                            s_d.wcnt     = '0;
                        end else begin
                            s_d.mode = MODE_DROP;
                        end
                    end
                    default: s_d.mode = MODE_PASS;
                endcase
            end
            unique case (s_d.mode)
                MODE_DATA: begin
                    if (s_d.wcnt < LW'(DEPTH)) begin
                        s_d.data_we    = 1'b1;
                        s_d.data_addr  = {s_d.cur_bank, s_d.wcnt[DAW-1:0]};
                        s_d.data_wdata = in_data;
                        s_d.wcnt       = s_d.wcnt + 1'b1;
                    end
                    if (in_eop) begin
                        s_d.full[s_d.cur_bank] = 1'b1;
                        s_d.len[s_d.cur_bank]  = s_d.wcnt;
                        s_d.ptr                = s_d.cur_bank + 1'b1;
                        s_d.mode               = MODE_IDLE;
                    end
                end
                MODE_PROG: begin
                    if (in_pay) begin
                        if (!s_d.seen_tag) begin
                            s_d.seen_tag = 1'b1;
                        end else if (s_d.pcnt < PLW'(PDEPTH)) begin
                            s_d.prog_we    = 1'b1;
                            s_d.prog_addr  = {s_d.pbank, s_d.pcnt[PAW-1:0]};
                            s_d.prog_wdata = in_data;
                            s_d.pcnt       = s_d.pcnt + 1'b1;
                        end
                    end
                    if (in_eop) begin
                        s_d.prog_done      = 1'b1;
                        s_d.prog_done_bank = s_d.pbank;
                        s_d.pbank          = ~s_d.pbank;
                        s_d.mode           = MODE_IDLE;
                    end
                end
                MODE_PASS: begin
                    s_d.pass_valid = 1'b1;
                    s_d.pass_data  = in_data;
                    if (in_eop) s_d.mode = MODE_IDLE;
                end
                MODE_DROP: begin
                    if (in_eop) s_d.mode = MODE_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready       = ~&s_q.full;
    assign data_we        = s_q.data_we;
    assign data_addr      = s_q.data_addr;
    assign data_wdata     = s_q.data_wdata;
    assign prog_we        = s_q.prog_we;
    assign prog_addr      = s_q.prog_addr;
    assign prog_wdata     = s_q.prog_wdata;
    assign prog_done      = s_q.prog_done;
    assign prog_done_bank = s_q.prog_done_bank;
    assign pass_valid     = s_q.pass_valid;
    assign pass_data      = s_q.pass_data;
    assign wr_grant       = (s_q.mode == MODE_DATA);
    assign bank_full      = s_q.full;
    assign bank_len       = s_q.len;

    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_DATA) |-> !s_q.full[s_q.cur_bank]);

    assert_single_sink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_we, prog_we, pass_valid}));

    assert_fill_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_full) <= $past($countones(bank_full)) + 1);

    assert_prog_bank_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> (prog_done_bank != s_q.pbank));

    assert_grant_quiet_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> !pass_valid && !prog_we);
endmodule

// File: tb/pbs_store_ctrl_tb.sv
module pbs_store_ctrl_tb;
    localparam int NB = 4, DEPTH = 16, PDEPTH = 16;
    localparam int BW = 2, DAW = 4, LW = 5, PAW = 4;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_pay = 0, cls_udp = 0;
    logic [31:0] in_data = 0, cls_tag = 0;
    logic free_valid = 0;
    logic [BW-1:0] free_idx = 0;
    logic in_ready, data_we, prog_we, prog_done, prog_done_bank, pass_valid, wr_grant;
    logic [BW+DAW-1:0] data_addr;
    logic [PAW:0] prog_addr;
    logic [31:0] data_wdata, prog_wdata, pass_data;
    logic [NB-1:0] bank_full;
    logic [NB*LW-1:0] bank_len;

    always #2.5 clk = ~clk;

    pbs_store_ctrl #(.NB(NB), .DEPTH(DEPTH), .PDEPTH(PDEPTH)) u_dut (.*);

    int errors = 0, checks = 0;
    bit finished = 0;

    // reference model state
    int m_mode = 0; // 0 idle 1 prog 2 data 3 pass 4 drop
    int m_bank = 0, m_cnt = 0, m_pcnt = 0, m_seen = 0, m_ptr = 0, m_pbank = 0;
    int m_full[NB], m_len[NB];
    int e_dwe = 0, e_daddr = 0, e_pwe = 0, e_paddr = 0, e_pv = 0, e_pdone = 0, e_pdbank = 0;
    logic [31:0] e_dwd = 0, e_pwd = 0, e_pvd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ptr = 0; m_pbank = 0;
            for (int i = 0; i < NB; i++) begin m_full[i] = 0; m_len[i] = 0; end
            e_dwe = 0; e_pwe = 0; e_pv = 0; e_pdone = 0;
        end else begin
            e_dwe = 0; e_pwe = 0; e_pv = 0; e_pdone = 0;
            if (free_valid) m_full[free_idx] = 0;
            if (in_valid) begin
                if (in_sop) begin
                    if (!cls_udp || (cls_tag != 0 && cls_tag != 1)) m_mode = 3;
                    else if (cls_tag == 0) begin m_mode = 1; m_pcnt = 0; m_seen = 0; end
                    else begin
                        m_mode = 4;
                        for (int k = 0; k < NB; k++)
                            if (m_mode == 4 && !m_full[(m_ptr + k) % NB]) begin
                                m_mode = 2; m_bank = (m_ptr + k) % NB; m_cnt = 0;
                            end
                    end
                end
                case (m_mode)
                    2: begin
                        if (m_cnt < DEPTH) begin
                            e_dwe = 1; e_daddr = m_bank * DEPTH + m_cnt; e_dwd = in_data;
                            m_cnt++;
                        end
                        if (in_eop) begin
                            m_full[m_bank] = 1; m_len[m_bank] = m_cnt;
                            m_ptr = (m_bank + 1) % NB; m_mode = 0;
                        end
                    end
                    1: begin
                        if (in_pay) begin
                            if (!m_seen) m_seen = 1;
                            else if (m_pcnt < PDEPTH) begin
                                e_pwe = 1; e_paddr = m_pbank * PDEPTH + m_pcnt; e_pwd = in_data;
                                m_pcnt++;
                            end
                        end
                        if (in_eop) begin
                            e_pdone = 1; e_pdbank = m_pbank; m_pbank = 1 - m_pbank; m_mode = 0;
                        end
                    end
                    3: begin
                        e_pv = 1; e_pvd = in_data;
                        if (in_eop) m_mode = 0;
                    end
                    4: if (in_eop) m_mode = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int allf;
            allf = 1;
            for (int i = 0; i < NB; i++) if (!m_full[i]) allf = 0;
            // R2 R5 data port
            chk(data_we == e_dwe, "R2 data_we", data_we, e_dwe);
            if (e_dwe) begin
                chk(data_addr == e_daddr, "R4 data_addr", data_addr, e_daddr);
                chk(data_wdata == e_dwd, "R2 data_wdata", data_wdata, e_dwd);
            end
            // R1 R8 program port
            chk(prog_we == e_pwe, "R1 prog_we", prog_we, e_pwe);
            if (e_pwe) begin
                chk(prog_addr == e_paddr, "R1 prog_addr", prog_addr, e_paddr);
                chk(prog_wdata == e_pwd, "R1 prog_wdata", prog_wdata, e_pwd);
            end
            chk(prog_done == e_pdone, "R8 prog_done", prog_done, e_pdone);
            if (e_pdone) chk(prog_done_bank == e_pdbank, "R8 prog_done_bank", prog_done_bank, e_pdbank);
            // R3 pass-through
            chk(pass_valid == e_pv, "R3 pass_valid", pass_valid, e_pv);
            if (e_pv) chk(pass_data == e_pvd, "R3 pass_data", pass_data, e_pvd);
            // R9 grant
            chk(wr_grant == (m_mode == 2), "R9 wr_grant", wr_grant, m_mode == 2);
            // R6 R7 flags
            chk(in_ready == !allf, "R6 in_ready", in_ready, !allf);
            for (int i = 0; i < NB; i++) begin
                chk(bank_full[i] == m_full[i], "R7 bank_full", bank_full[i], m_full[i]);
                chk(bank_len[i*LW +: LW] == m_len[i], "R5 bank_len", bank_len[i*LW +: LW], m_len[i]);
            end
        end
    end

    logic [31:0] seed = 32'h1000;

    task automatic send(input bit udp, input logic [31:0] tag, input int nh, input int np, input int nt);
        int n;
        n = nh + np + nt;
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            in_valid = 1;
            in_sop = (w == 0);
            in_eop = (w == n - 1);
            in_pay = (w >= nh) && (w < nh + np);
            cls_udp = udp;
            cls_tag = tag;
            seed = seed + 32'h11;
            in_data = (w == nh) ? tag : seed;
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; in_pay = 0;
        @(negedge clk);
    endtask

    task automatic free_bank(input int b);
        @(negedge clk);
        free_valid = 1; free_idx = BW'(b);
        @(negedge clk);
        free_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(data_we == 0 && prog_we == 0 && pass_valid == 0 && prog_done == 0, "R10 reset outputs", 0, 0);
        chk(in_ready == 1 && bank_full == 0 && wr_grant == 0, "R10 reset flags", bank_full, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        send(1, 32'h0, 3, 6, 2);           // R1 program -> bank 0
        send(1, 32'h1, 3, 4, 2);           // R2 data -> bank 0
        send(1, 32'h5, 2, 3, 1);           // R3 unknown tag
        send(0, 32'h1, 2, 3, 1);           // R3 non-UDP
        send(1, 32'h1, 0, 1, 0);           // R2 single word -> bank 1 len 1
        send(1, 32'h1, 3, 20, 2);          // R5 long -> bank 2 len 16
        send(1, 32'h1, 1, 2, 1);           // R4 -> bank 3, all full
        send(1, 32'h1, 2, 2, 1);           // R6 dropped
        free_bank(2);                      // R7
        send(1, 32'h1, 1, 3, 1);           // R4 wrap search -> bank 2
        fork
            send(1, 32'h0, 2, 20, 1);      // R8 long program -> bank 1
            begin repeat (4) @(negedge clk); free_bank(0); end
        join
        send(1, 32'h1, 2, 2, 2);           // R4 -> bank 0 after free mid-program
        send(1, 32'h0, 0, 3, 0);           // R8 back to bank 0
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule